// File: doc/BRIEF.md
# Unified-Address Register File

This block is the working register file of an 8-bit RISC core. Each cycle it serves two operands to the ALU and accepts one result write. It also shows three register pairs as 16-bit pointers for indirect addressing, with an atomic pointer increment or decrement port.

The same 32 registers sit at the bottom of a unified 16-bit data address space, so loads and stores can reach them like memory. The block decodes every data-space access into one of three regions. The register file covers 0x00 to 0x1F. A 64-location I/O window covers 0x20 to 0x5F and is forwarded to an I/O port, whose address is the data address minus 0x20. Everything from 0x60 up is forwarded to an SRAM port. The ALU, the instruction decoder, the SRAM and the peripherals all lie outside the block.

Top module: `dspace_regfile`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge, clears all 32 registers and so all three pointers to zero.
- R2: Both ALU read ports are combinational. In a cycle where the same register is being written, they return the value held before that edge.
- R3: When `wr_en` is high, `wr_data` is stored into register `wr_sel` at the rising clock edge.
- R4: `ptr_x` is {r27, r26}, `ptr_y` is {r29, r28} and `ptr_z` is {r31, r30}. The lower-numbered register of each pair is the low byte.
- R5: A data-space access with address 0x00 to 0x1F reads or writes register `ds_addr[4:0]`. It raises no I/O or SRAM strobe.
- R6: An access with address 0x20 to 0x5F raises `io_rd` or `io_wr` with `io_addr` = `ds_addr` − 0x20, and `ds_rdata` returns `io_rdata`. No register and no SRAM strobe is touched.
- R7: An access with address 0x60 or above raises `sram_rd` or `sram_wr` with `sram_addr` = `ds_addr`, and `ds_rdata` returns `sram_rdata`. No register and no I/O strobe is touched.
- R8: When the ALU port and the data-space port write the same register in one cycle, the ALU value is stored.
- R9: With `ptr_step_en` high, the pair chosen by `ptr_sel` (0 = X, 1 = Y, 2 = Z) becomes its value plus 1 when `ptr_up` = 1, or minus 1 when `ptr_up` = 0. Both bytes change at one edge and the result wraps modulo 2^16. `ptr_sel` = 3 selects no pair and changes nothing.
- R10: Write priority is decided byte by byte. An ALU write to one byte of a stepped pair overrides that byte only, and the other byte takes the stepped value. A pointer step overrides a data-space write to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 5 | Operand A register select |
| rd_a_data | output | 8 | Operand A value |
| rd_b_sel | input | 5 | Operand B register select |
| rd_b_data | output | 8 | Operand B value |
| wr_en | input | 1 | ALU result write enable |
| wr_sel | input | 5 | ALU result destination register |
| wr_data | input | 8 | ALU result |
| ptr_step_en | input | 1 | Pointer step enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_up | input | 1 | 1 increments, 0 decrements |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| ptr_z | output | 16 | Pointer Z |
| ds_addr | input | 16 | Data-space address |
| ds_rd | input | 1 | Data-space read request |
| ds_wr | input | 1 | Data-space write request |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| io_addr | output | 6 | I/O location |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |
| sram_addr | output | 16 | SRAM address |
| sram_rd | output | 1 | SRAM read strobe |
| sram_wr | output | 1 | SRAM write strobe |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data |

## Verification
A wrongly updated register shows up one edge after the faulty write. It appears on whichever read port selects that register, and on a pointer output at once if the register belongs to a pair. A broken decode shows up in the same cycle as a strobe on the wrong port or a wrong `io_addr`. A pointer step that carries wrongly between its bytes, or a priority that is inverted, leaves a pointer value off by one byte one edge later. The boundary addresses 0x1F, 0x20, 0x5F and 0x60 and the wrap at 0xFFFF and 0x0000 are where such faults show.

// File: rtl/dspace_rf_pkg.sv
package dspace_rf_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 32;
    localparam int AW      = 16;
    localparam int IO_SPAN = 64;
    localparam int SEL_W   = $clog2(NREG);
    localparam int IO_AW   = $clog2(IO_SPAN);
    localparam int PTR_W   = 2 * DW;
    localparam int REG_TOP = NREG;
    localparam int IO_TOP  = NREG + IO_SPAN;
    localparam int PTR_BASE = NREG - 6;

    typedef enum logic [1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_SRAM = 2'd2
    } region_e;

    typedef struct packed {
        logic             we;
        logic [SEL_W-1:0] lo;
        logic [SEL_W-1:0] hi;
        logic [PTR_W-1:0] val;
    } ptr_upd_t;

    function automatic logic [SEL_W-1:0] ptr_low_reg(ptr_sel_e s);
        return SEL_W'(PTR_BASE + 2 * int'(s));
    endfunction
endpackage

// File: rtl/dspace_addr_decode.sv
module dspace_addr_decode
    import dspace_rf_pkg::*;
(
    input  logic [AW-1:0]    ds_addr,
    input  logic             ds_rd,
    input  logic             ds_wr,
    output region_e          region,
    output logic             reg_we,
    output logic [IO_AW-1:0] io_addr,
    output logic             io_rd,
    output logic             io_wr,
    output logic             sram_rd,
    output logic             sram_wr
);
    always_comb begin
        if (ds_addr < AW'(REG_TOP))      region = RGN_REG;
        else if (ds_addr < AW'(IO_TOP))  region = RGN_IO;
        else                             region = RGN_SRAM;
    end

    assign io_addr = IO_AW'(ds_addr - AW'(REG_TOP));
    assign reg_we  = ds_wr && (region == RGN_REG);
    assign io_rd   = ds_rd && (region == RGN_IO);
    assign io_wr   = ds_wr && (region == RGN_IO);
    assign sram_rd = ds_rd && (region == RGN_SRAM);
    assign sram_wr = ds_wr && (region == RGN_SRAM);
endmodule

// File: rtl/dspace_ptr_step.sv
module dspace_ptr_step
    import dspace_rf_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0] bank_q,
    input  logic                    en,
    input  ptr_sel_e                sel,
    input  logic                    up,
    output ptr_upd_t                upd
);
    logic [PTR_W-1:0] cur;

    always_comb begin
        upd.lo  = ptr_low_reg(sel);
        upd.hi  = upd.lo + SEL_W'(1);
        upd.we  = en && (sel != PTR_NONE);
        cur     = {bank_q[upd.hi], bank_q[upd.lo]};
        upd.val = up ? cur + PTR_W'(1) : cur - PTR_W'(1);
    end
endmodule

// File: rtl/dspace_bank.sv
module dspace_bank
    import dspace_rf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alu_we,
    input  logic [SEL_W-1:0]        alu_sel,
    input  logic [DW-1:0]           alu_d,
    input  ptr_upd_t                pupd,
    input  logic                    ds_we,
    input  logic [SEL_W-1:0]        ds_sel,
    input  logic [DW-1:0]           ds_d,
    output logic [NREG-1:0][DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (alu_we && alu_sel == SEL_W'(i))
                    q[i] <= alu_d;
                else if (pupd.we && pupd.lo == SEL_W'(i))
                    q[i] <= pupd.val[DW-1:0];
                else if (pupd.we && pupd.hi == SEL_W'(i))
                    q[i] <= pupd.val[PTR_W-1:DW];
                else if (ds_we && ds_sel == SEL_W'(i))
                    q[i] <= ds_d;
            end
        end
    end
endmodule

// File: rtl/dspace_regfile.sv
module dspace_regfile
    import dspace_rf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SEL_W-1:0]        rd_a_sel,
    output logic [DW-1:0]           rd_a_data,
    input  logic [SEL_W-1:0]        rd_b_sel,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DW-1:0]           wr_data,
    input  logic                    ptr_step_en,
    input  logic [1:0]              ptr_sel,
    input  logic                    ptr_up,
    output logic [PTR_W-1:0]        ptr_x,
    output logic [PTR_W-1:0]        ptr_y,
    output logic [PTR_W-1:0]        ptr_z,
    input  logic [AW-1:0]           ds_addr,
    input  logic                    ds_rd,
    input  logic                    ds_wr,
    input  logic [DW-1:0]           ds_wdata,
    output logic [DW-1:0]           ds_rdata,
    output logic [IO_AW-1:0]        io_addr,
    output logic                    io_rd,
    output logic                    io_wr,
    output logic [DW-1:0]           io_wdata,
    input  logic [DW-1:0]           io_rdata,
    output logic [AW-1:0]           sram_addr,
    output logic                    sram_rd,
    output logic                    sram_wr,
    output logic [DW-1:0]           sram_wdata,
    input  logic [DW-1:0]           sram_rdata
);
    logic [NREG-1:0][DW-1:0] bank_q;
    region_e                 region;
    logic                    ds_reg_we;
    ptr_upd_t                pupd;

    dspace_addr_decode u_dec (
        .ds_addr (ds_addr),
        .ds_rd   (ds_rd),
        .ds_wr   (ds_wr),
        .region  (region),
        .reg_we  (ds_reg_we),
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .sram_rd (sram_rd),
        .sram_wr (sram_wr)
    );

    dspace_ptr_step u_step (
        .bank_q (bank_q),
        .en     (ptr_step_en),
        .sel    (ptr_sel_e'(ptr_sel)),
        .up     (ptr_up),
        .upd    (pupd)
    );

    dspace_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .alu_we  (wr_en),
        .alu_sel (wr_sel),
        .alu_d   (wr_data),
        .pupd    (pupd),
        .ds_we   (ds_reg_we),
        .ds_sel  (ds_addr[SEL_W-1:0]),
        .ds_d    (ds_wdata),
        .q       (bank_q)
    );

    assign rd_a_data  = bank_q[rd_a_sel];
    assign rd_b_data  = bank_q[rd_b_sel];
    assign ptr_x      = {bank_q[PTR_BASE+1], bank_q[PTR_BASE]};
    assign ptr_y      = {bank_q[PTR_BASE+3], bank_q[PTR_BASE+2]};
    assign ptr_z      = {bank_q[PTR_BASE+5], bank_q[PTR_BASE+4]};
    assign io_wdata   = ds_wdata;
    assign sram_addr  = ds_addr;
    assign sram_wdata = ds_wdata;

    always_comb begin
        case (region)
            RGN_REG: ds_rdata = bank_q[ds_addr[SEL_W-1:0]];
            RGN_IO:  ds_rdata = io_rdata;
            default: ds_rdata = sram_rdata;
        endcase
    end
endmodule

// File: rtl/dspace_regfile_chk.sv
module dspace_regfile_chk
    import dspace_rf_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [SEL_W-1:0]        wr_sel,
    input logic [DW-1:0]           wr_data,
    input logic                    ds_wr,
    input logic [AW-1:0]           ds_addr,
    input logic                    ptr_step_en,
    input logic [1:0]              ptr_sel,
    input logic                    ptr_up,
    input logic [PTR_W-1:0]        ptr_x,
    input logic                    io_rd,
    input logic                    io_wr,
    input logic                    sram_rd,
    input logic                    sram_wr,
    input logic [NREG-1:0][DW-1:0] bank_q
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bank_q == '0));

    // R3 and R8: the ALU value always lands, whatever the other ports do
    p_alu_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bank_q[$past(wr_sel)] == $past(wr_data));

    p_ptr_inc_r9: assert property (@(posedge clk) disable iff (rst)
        (ptr_step_en && ptr_sel == 2'd0 && ptr_up && !wr_en && !ds_wr)
        |=> ptr_x == $past(ptr_x) + PTR_W'(1));

    p_region_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_rd | io_wr, sram_rd | sram_wr}));

    p_io_range_r6: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr) |-> (ds_addr >= AW'(REG_TOP) && ds_addr < AW'(IO_TOP)));

    p_sram_range_r7: assert property (@(posedge clk) disable iff (rst)
        (sram_rd || sram_wr) |-> ds_addr >= AW'(IO_TOP));

    p_reg_region_r5: assert property (@(posedge clk) disable iff (rst)
        (ds_wr && ds_addr < AW'(REG_TOP)) |-> (!io_wr && !sram_wr));
endmodule

bind dspace_regfile dspace_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .ds_wr       (ds_wr),
    .ds_addr     (ds_addr),
    .ptr_step_en (ptr_step_en),
    .ptr_sel     (ptr_sel),
    .ptr_up      (ptr_up),
    .ptr_x       (ptr_x),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .sram_rd     (sram_rd),
    .sram_wr     (sram_wr),
    .bank_q      (bank_q)
);

// File: tb/dspace_regfile_bench.sv
module dspace_regfile_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_sel, rd_b_sel, wr_sel;
    logic [7:0]  rd_a_data, rd_b_data, wr_data;
    logic        wr_en, ptr_step_en, ptr_up;
    logic [1:0]  ptr_sel;
    logic [15:0] ptr_x, ptr_y, ptr_z;
    logic [15:0] ds_addr, sram_addr;
    logic        ds_rd, ds_wr, io_rd, io_wr, sram_rd, sram_wr;
    logic [7:0]  ds_wdata, ds_rdata, io_wdata, sram_wdata;
    logic [7:0]  io_rdata = 8'h5C;
    logic [7:0]  sram_rdata = 8'hE3;
    logic [5:0]  io_addr;
    int          n_total = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    dspace_regfile u_dspace_regfile (.*);

    localparam logic [12:0] VEC [8] = '{
        {5'd0, 8'h01}, {5'd1, 8'hFE}, {5'd7, 8'h80}, {5'd15, 8'h7F},
        {5'd16, 8'hAA}, {5'd25, 8'h55}, {5'd26, 8'hC3}, {5'd31, 8'h3C}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0;
        ptr_step_en = 0; ptr_sel = 2'd3; ptr_up = 0;
        ds_addr = 0; ds_rd = 0; ds_wr = 0; ds_wdata = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic alu_wr(logic [4:0] s, logic [7:0] d);
        idle(); wr_en = 1; wr_sel = s; wr_data = d;
        step(); idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        idle(); rd_a_sel = 0; rd_b_sel = 0; rst = 1;
        step(); step();
        rst = 0;
        // R1: reset state
        for (int i = 0; i < 32; i++) begin
            rd_a_sel = 5'(i); #1;
            chk("R1 reg after reset", rd_a_data, 0);
        end
        chk("R1 pointers after reset", {ptr_x, ptr_y, ptr_z}, 0);

        // R3 / R2: vector table walk
        for (int k = 0; k < 8; k++) begin
            alu_wr(VEC[k][12:8], VEC[k][7:0]);
            rd_a_sel = VEC[k][12:8]; rd_b_sel = VEC[k][12:8]; #1;
            chk("R3 port A", rd_a_data, VEC[k][7:0]);
            chk("R3 port B", rd_b_data, VEC[k][7:0]);
        end

        // R2: read during write sees old value
        wr_en = 1; wr_sel = 5'd7; wr_data = 8'h99; rd_a_sel = 5'd7; #1;
        chk("R2 old value in write cycle", rd_a_data, 8'h80);
        step(); idle(); #1;
        chk("R2 new value after edge", rd_a_data, 8'h99);

        // R4: pointer composition
        alu_wr(5'd26, 8'h34); alu_wr(5'd27, 8'h12);
        alu_wr(5'd28, 8'h78); alu_wr(5'd29, 8'h56);
        alu_wr(5'd30, 8'hBC); alu_wr(5'd31, 8'h9A);
        chk("R4 ptr_x", ptr_x, 16'h1234);
        chk("R4 ptr_y", ptr_y, 16'h5678);
        chk("R4 ptr_z", ptr_z, 16'h9ABC);

        // R5: register region through data space
        ds_addr = 16'h0009; ds_wr = 1; ds_wdata = 8'hA5; #1;
        chk("R5 no io/sram strobe", {io_wr, sram_wr, io_rd, sram_rd}, 0);
        step(); idle(); rd_a_sel = 5'd9; #1;
        chk("R5 ds write to r9", rd_a_data, 8'hA5);
        ds_addr = 16'h001F; ds_rd = 1; #1;
        chk("R5 ds read of 0x1F", ds_rdata, 8'h9A);
        chk("R5 read no strobe", {io_rd, sram_rd}, 0);

        // R6: I/O window
        idle(); ds_addr = 16'h0020; ds_wr = 1; ds_wdata = 8'h11; #1;
        chk("R6 io strobe at 0x20", {io_wr, sram_wr}, 2'b10);
        chk("R6 io_addr at 0x20", io_addr, 0);
        chk("R6 io_wdata", io_wdata, 8'h11);
        step(); idle(); rd_a_sel = 5'd0; #1;
        chk("R6 r0 untouched", rd_a_data, 8'h01);
        ds_addr = 16'h005F; ds_rd = 1; #1;
        chk("R6 io read at 0x5F", {io_rd, sram_rd}, 2'b10);
        chk("R6 io_addr at 0x5F", io_addr, 6'h3F);
        chk("R6 ds_rdata from io", ds_rdata, 8'h5C);
        idle(); ds_addr = 16'h003F; ds_wr = 1; ds_wdata = 8'h00;
        step(); idle(); rd_a_sel = 5'd31; #1;
        chk("R6 r31 untouched", rd_a_data, 8'h9A);

        // R7: SRAM region
        ds_addr = 16'h0060; ds_wr = 1; ds_wdata = 8'h42; #1;
        chk("R7 sram strobe at 0x60", {sram_wr, io_wr}, 2'b10);
        chk("R7 sram_addr", sram_addr, 16'h0060);
        chk("R7 sram_wdata", sram_wdata, 8'h42);
        step(); idle(); rd_a_sel = 5'd0; #1;
        chk("R7 r0 untouched", rd_a_data, 8'h01);
        ds_addr = 16'hFFFF; ds_rd = 1; #1;
        chk("R7 sram read", {sram_rd, io_rd}, 2'b10);
        chk("R7 ds_rdata from sram", ds_rdata, 8'hE3);
        idle();

        // R8: ALU beats data space
        wr_en = 1; wr_sel = 5'd9; wr_data = 8'h11;
        ds_addr = 16'h0009; ds_wr = 1; ds_wdata = 8'h22;
        step(); idle(); rd_a_sel = 5'd9; #1;
        chk("R8 ALU wins", rd_a_data, 8'h11);

        // R9: pointer steps and wrap
        ptr_step_en = 1; ptr_sel = 2'd0; ptr_up = 1;
        step(); idle();
        chk("R9 X increment", ptr_x, 16'h1235);
        alu_wr(5'd30, 8'hFF); alu_wr(5'd31, 8'hFF);
        ptr_step_en = 1; ptr_sel = 2'd2; ptr_up = 1;
        step(); idle();
        chk("R9 Z wrap up", ptr_z, 16'h0000);
        ptr_step_en = 1; ptr_sel = 2'd2; ptr_up = 0;
        step(); idle();
        chk("R9 Z wrap down", ptr_z, 16'hFFFF);
        alu_wr(5'd28, 8'h00); alu_wr(5'd29, 8'h01);
        ptr_step_en = 1; ptr_sel = 2'd1; ptr_up = 0;
        step(); idle();
        chk("R9 Y borrow", ptr_y, 16'h00FF);
        ptr_step_en = 1; ptr_sel = 2'd3; ptr_up = 1;
        step(); idle();
        chk("R9 sel 3 ignored", {ptr_x, ptr_y, ptr_z}, {16'h1235, 16'h00FF, 16'hFFFF});

        // R10: byte-wise priority
        alu_wr(5'd30, 8'hFF); alu_wr(5'd31, 8'h00);
        ptr_step_en = 1; ptr_sel = 2'd2; ptr_up = 1;
        wr_en = 1; wr_sel = 5'd30; wr_data = 8'h77;
        step(); idle();
        chk("R10 ALU over step byte", ptr_z, 16'h0177);
        ptr_step_en = 1; ptr_sel = 2'd2; ptr_up = 1;
        ds_addr = 16'h001F; ds_wr = 1; ds_wdata = 8'h99;
        step(); idle();
        chk("R10 step over ds", ptr_z, 16'h0178);

        // R1: reset after activity
        rst = 1; step(); rst = 0;
        chk("R1 pointers cleared", {ptr_x, ptr_y, ptr_z}, 0);
        rd_a_sel = 5'd9; rd_b_sel = 5'd16; #1;
        chk("R1 regs cleared", {rd_a_data, rd_b_data}, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule